// File: doc/BRIEF.md
# Programmable Logic Configuration Phase Sequencer

This block is the control state machine that walks a reconfigurable device from an empty state to normal operation. It starts when reset is released, or when an active-low program request arrives. It clears the configuration memory, waits for the shared INIT line, captures the boot-mode pins and then waits while the data stream loads. Once loading is complete, it runs a start-up sequence that releases the device's global controls one at a time.

The INIT and DONE lines are open-drain and are shared with other devices. Each one is modelled as two signals. The first is a pull-low enable that this block drives. The second is a sensed level, which is the wired-AND of all devices on the line. Another device can therefore stall initialization by holding INIT low. A chain of devices can also start up together, because each one pauses after it releases DONE until the shared DONE line actually rises. The memory array, the bitstream shifter and the CRC arithmetic sit outside this block. They report to it through the pass-complete, load-complete and CRC-error inputs.

Top module: `cfg_phase_seq`

## Requirements
- R1: While reset is held and right after it is released, `state_o` is 0 (clear phase), `init_pull` and `done_pull` are 1, `io_en` and `gwe_en` are 0, and `gsr` is 1.
- R2: In the clear phase, a `clr_pass_done` pulse that arrives while the program request is still asserted starts another pass, so the state stays 0. A pulse that arrives with the request negated moves the state to 1 (initialization) on the next clock.
- R3: In initialization, `init_pull` is 0 and `done_pull` is 1. The state stays 1 for every cycle in which `init_sense` is low.
- R4: In initialization, the first cycle with `init_sense` high captures `mode_pins` into `cfg_mode` and moves the state to 2 (loading). After that, changes on `mode_pins` leave `cfg_mode` unchanged.
- R5: In loading, a cycle with `crc_err` high moves the state to 3 (error) and sets `init_pull` to 1. Once in the error state, `load_done` is ignored: the state stays 3, `done_pull` stays 1 and `io_en` stays 0.
- R6: In loading with `sync_done_mode` low, `load_done` starts a start-up sequence that spends one clock in each step:
  - state 4: `done_pull` drops to 0;
  - state 5: `io_en` rises;
  - state 6: `gwe_en` rises;
  - state 7: `gsr` drops to 0;
  - then state 8 (operational), where the block stays.
- R7: With `sync_done_mode` high, the block stays in state 4 with `done_pull` 0 and `io_en` 0 until `done_sense` is high. It moves to state 5 on the clock after `done_sense` goes high.
- R8: `prog_n` passes through a two-stage synchronizer. When it is driven low in any phase other than clear, the state is still unchanged after two clock edges and is 0 after the third, with `init_pull` 1 and `io_en` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset, acting as power-up |
| prog_n | input | 1 | Asynchronous active-low program request |
| init_sense | input | 1 | Sensed level of the shared INIT line |
| done_sense | input | 1 | Sensed level of the shared DONE line |
| mode_pins | input | MODE_W | Boot-mode select pins |
| clr_pass_done | input | 1 | Pulse marking the end of one memory-clear pass |
| load_done | input | 1 | Data stream fully loaded |
| crc_err | input | 1 | CRC mismatch reported by the loader |
| sync_done_mode | input | 1 | Option: pause start-up until DONE is high externally |
| init_pull | output | 1 | Pull-low enable for INIT |
| done_pull | output | 1 | Pull-low enable for DONE |
| io_en | output | 1 | User I/O enable |
| gwe_en | output | 1 | Global write enable (1 = writes allowed) |
| gsr | output | 1 | Global reset (1 = user logic held in reset) |
| cfg_mode | output | MODE_W | Captured boot mode |
| state_o | output | 4 | Phase code: 0 clear, 1 init, 2 load, 3 error, 4–7 start-up steps, 8 operational |

## Verification
The bench checks that a clear pass ending while the program request is still asserted repeats instead of advancing. A design that only looked at the request at the start of clearing would move to initialization too early. It holds the INIT line low for several cycles and then changes the mode pins after capture. This catches a sequencer that ignores the external stall, or one that keeps tracking the mode pins. It follows the start-up releases cycle by cycle, both with and without the DONE pause, so a reordered or merged step shows up as a wrong output in a specific cycle. It also checks two more cases. After a CRC error, a later load-complete must not start start-up. A program request from the operational and error states must return to clearing exactly three edges after it is asserted.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
   localparam int STATE_W = 4;

   typedef enum logic [STATE_W-1:0] {
      PH_CLEAR   = 4'd0,
      PH_INIT    = 4'd1,
      PH_LOAD    = 4'd2,
      PH_ERROR   = 4'd3,
      PH_SU_DONE = 4'd4,
      PH_SU_IO   = 4'd5,
      PH_SU_GWE  = 4'd6,
      PH_SU_GSR  = 4'd7,
      PH_RUN     = 4'd8
   } phase_t;
endpackage

// File: rtl/cfg_req_sync.sv
module cfg_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic req
);
   initial begin
      if (STAGES < 2) $error("cfg_req_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], async_n};
   end

   assign req = ~chain[STAGES-1];
endmodule

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] pins,
   output logic [W-1:0] mode
);
   initial begin
      if (W < 1) $error("cfg_mode_latch: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode <= '0;
      else if (capture) mode <= pins;
   end
endmodule

// File: rtl/cfg_out_decode.sv
module cfg_out_decode
   import cfg_seq_pkg::*;
(
   input  phase_t ph,
   output logic   init_pull,
   output logic   done_pull,
   output logic   io_en,
   output logic   gwe_en,
   output logic   gsr
);
   always_comb begin
      init_pull = 1'b0;
      done_pull = 1'b1;
      io_en     = 1'b0;
      gwe_en    = 1'b0;
      gsr       = 1'b1;
      case (ph)
         PH_CLEAR, PH_ERROR: init_pull = 1'b1;
         PH_INIT, PH_LOAD:   ;
         PH_SU_DONE:         done_pull = 1'b0;
         PH_SU_IO: begin
            done_pull = 1'b0;
            io_en     = 1'b1;
         end
         PH_SU_GWE: begin
            done_pull = 1'b0;
            io_en     = 1'b1;
            gwe_en    = 1'b1;
         end
         default: begin
            done_pull = 1'b0;
            io_en     = 1'b1;
            gwe_en    = 1'b1;
            gsr       = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/cfg_phase_seq.sv
module cfg_phase_seq
   import cfg_seq_pkg::*;
#(
   parameter int MODE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_n,
   input  logic              init_sense,
   input  logic              done_sense,
   input  logic [MODE_W-1:0] mode_pins,
   input  logic              clr_pass_done,
   input  logic              load_done,
   input  logic              crc_err,
   input  logic              sync_done_mode,
   output logic              init_pull,
   output logic              done_pull,
   output logic              io_en,
   output logic              gwe_en,
   output logic              gsr,
   output logic [MODE_W-1:0] cfg_mode,
   output logic [3:0]        state_o
);
   initial begin
      if (MODE_W < 1 || MODE_W > 8) $error("cfg_phase_seq: MODE_W out of range");
      if (SYNC_STAGES < 2)          $error("cfg_phase_seq: SYNC_STAGES too small");
   end

   phase_t ph, ph_nx;
   logic   prog_req;
   logic   capture;

   cfg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_n(prog_n), .req(prog_req)
   );

   assign capture = (ph == PH_INIT) && init_sense && !prog_req;

   cfg_mode_latch #(.W(MODE_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .capture(capture), .pins(mode_pins), .mode(cfg_mode)
   );

   cfg_out_decode u_dec (
      .ph(ph), .init_pull(init_pull), .done_pull(done_pull),
      .io_en(io_en), .gwe_en(gwe_en), .gsr(gsr)
   );

   always_comb begin
      ph_nx = ph;
      if (prog_req && ph != PH_CLEAR) begin
         ph_nx = PH_CLEAR;
      end else begin
         case (ph)
            PH_CLEAR:   if (clr_pass_done && !prog_req) ph_nx = PH_INIT;
            PH_INIT:    if (init_sense) ph_nx = PH_LOAD;
            PH_LOAD: begin
               if (crc_err)        ph_nx = PH_ERROR;
               else if (load_done) ph_nx = PH_SU_DONE;
            end
            PH_ERROR:   ph_nx = PH_ERROR;
            PH_SU_DONE: if (!sync_done_mode || done_sense) ph_nx = PH_SU_IO;
            PH_SU_IO:   ph_nx = PH_SU_GWE;
            PH_SU_GWE:  ph_nx = PH_SU_GSR;
            PH_SU_GSR:  ph_nx = PH_RUN;
            default:    ph_nx = PH_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_CLEAR;
      else        ph <= ph_nx;
   end

   assign state_o = ph;

   assert_repeat_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_CLEAR && clr_pass_done && prog_req) |=> ph == PH_CLEAR);
   assert_init_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_INIT && !init_sense && !prog_req) |=> ph == PH_INIT);
   assert_mode_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_LOAD && !prog_req) |=> $stable(cfg_mode));
   assert_error_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_ERROR && !prog_req) |=> (ph == PH_ERROR && init_pull));
   assert_gwe_after_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gwe_en) |-> (io_en && $past(io_en)));
   assert_done_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_SU_DONE && sync_done_mode && !done_sense && !prog_req) |=> (ph == PH_SU_DONE && !io_en));
   assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req && ph != PH_CLEAR) |=> (ph == PH_CLEAR && init_pull && done_pull));
endmodule

// File: tb/cfg_phase_seq_tb.sv
module cfg_phase_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prog_n = 1'b1;
   logic       init_sense = 1'b0;
   logic       done_sense = 1'b0;
   logic [2:0] mode_pins = 3'd0;
   logic       clr_pass_done = 1'b0;
   logic       load_done = 1'b0;
   logic       crc_err = 1'b0;
   logic       sync_done_mode = 1'b0;
   logic       init_pull, done_pull, io_en, gwe_en, gsr;
   logic [2:0] cfg_mode;
   logic [3:0] state_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   cfg_phase_seq u_dut (
      .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .init_sense(init_sense),
      .done_sense(done_sense), .mode_pins(mode_pins), .clr_pass_done(clr_pass_done),
      .load_done(load_done), .crc_err(crc_err), .sync_done_mode(sync_done_mode),
      .init_pull(init_pull), .done_pull(done_pull), .io_en(io_en), .gwe_en(gwe_en),
      .gsr(gsr), .cfg_mode(cfg_mode), .state_o(state_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_pulse();
      clr_pass_done = 1'b1;
      step(1);
      clr_pass_done = 1'b0;
   endtask

   task automatic t_reset();
      step(2);
      check("R1 state in reset", state_o, 0);
      rst_n = 1'b1;
      step(1);
      check("R1 state", state_o, 0);
      check("R1 init_pull", init_pull, 1);
      check("R1 done_pull", done_pull, 1);
      check("R1 io_en", io_en, 0);
      check("R1 gwe_en", gwe_en, 0);
      check("R1 gsr", gsr, 1);
   endtask

   task automatic t_clear_repeat();
      prog_n = 1'b0;
      step(3);
      clear_pulse();
      check("R2 repeat pass", state_o, 0);
      prog_n = 1'b1;
      step(2);
      init_sense = 1'b0;
      clear_pulse();
      check("R2 advance", state_o, 1);
   endtask

   task automatic t_init_hold();
      for (int i = 0; i < 3; i++) begin
         check("R3 stall state", state_o, 1);
         check("R3 init_pull", init_pull, 0);
         check("R3 done_pull", done_pull, 1);
         step(1);
      end
      mode_pins  = 3'd5;
      init_sense = 1'b1;
      step(1);
      check("R4 to load", state_o, 2);
      check("R4 mode captured", cfg_mode, 5);
      mode_pins = 3'd2;
      step(2);
      check("R4 mode held", cfg_mode, 5);
   endtask

   task automatic t_startup();
      sync_done_mode = 1'b0;
      load_done = 1'b1;
      step(1);
      load_done = 1'b0;
      check("R6 step1 state", state_o, 4);
      check("R6 step1 done_pull", done_pull, 0);
      check("R6 step1 io_en", io_en, 0);
      step(1);
      check("R6 step2 state", state_o, 5);
      check("R6 step2 io_en", io_en, 1);
      check("R6 step2 gwe_en", gwe_en, 0);
      step(1);
      check("R6 step3 gwe_en", gwe_en, 1);
      check("R6 step3 gsr", gsr, 1);
      step(1);
      check("R6 step4 gsr", gsr, 0);
      check("R6 step4 state", state_o, 7);
      step(1);
      check("R6 run", state_o, 8);
      step(2);
      check("R6 run stays", state_o, 8);
   endtask

   task automatic t_abort(input string tag);
      prog_n = 1'b0;
      step(2);
      check({tag, " R8 not yet"}, (state_o == 0) ? 1 : 0, 0);
      step(1);
      check({tag, " R8 state"}, state_o, 0);
      check({tag, " R8 init_pull"}, init_pull, 1);
      check({tag, " R8 io_en"}, io_en, 0);
      prog_n = 1'b1;
      step(2);
      clear_pulse();
   endtask

   task automatic t_sync_done();
      mode_pins = 3'd3;
      step(1);
      check("R4 recapture", cfg_mode, 3);
      sync_done_mode = 1'b1;
      done_sense = 1'b0;
      load_done = 1'b1;
      step(1);
      load_done = 1'b0;
      step(3);
      check("R7 paused", state_o, 4);
      check("R7 done released", done_pull, 0);
      check("R7 io off", io_en, 0);
      done_sense = 1'b1;
      step(1);
      check("R7 resumed", state_o, 5);
      step(3);
      check("R7 run", state_o, 8);
      sync_done_mode = 1'b0;
      done_sense = 1'b0;
   endtask

   task automatic t_crc();
      check("R5 in load", state_o, 2);
      crc_err = 1'b1;
      step(1);
      crc_err = 1'b0;
      check("R5 error state", state_o, 3);
      check("R5 init_pull", init_pull, 1);
      load_done = 1'b1;
      step(2);
      load_done = 1'b0;
      check("R5 still error", state_o, 3);
      check("R5 done_pull", done_pull, 1);
      check("R5 io_en", io_en, 0);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_clear_repeat();
      t_init_hold();
      t_startup();
      t_abort("run");
      t_sync_done();
      t_abort("run2");
      step(1);
      t_crc();
      t_abort("error");
      check("R2 back to init", state_o, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule